// File: doc/BRIEF.md
# Boot-Time Register Setup Sequencer

This block is a small bus master that brings an embedded core into service after reset without an external processor. It waits until the core reports that it is ready. It then drives a fixed list of register writes onto a simple address, data and write-strobe bus. Each write completes only when the bus returns an acknowledge.

The list starts with a two-write unlock of the core's configuration registers. Next comes an optional group of eight writes that move the channel output buses from high impedance to their working state. After the writes, the block waits until every channel selected by a mask reports a valid frame pulse or a valid 8B/10B control character. It then emits a one-cycle request to resynchronise the alignment FIFO and raises a completion flag.

A write that is never acknowledged makes the sequence stop with an error flag. If core-ready is lost at any point, the block returns to idle. It repeats the whole list the next time core-ready rises.

Top module: `cfg_boot_seq`

## Requirements
- R1: While core-ready is low, or after reset, the strobe `bus_wr` is low and `bus_addr` and `bus_wdata` are zero. The flags `resync_pulse`, `seq_done` and `seq_err` are also low.
- R2: In the cycle after core-ready is first seen high, the first write starts with address 0x30004 and data 0x30005.
- R3: The second write uses address 0x00005 and data 0x80.
- R4: When `tristate_en` is high, eight writes of data 0x01 follow the unlock. Their addresses are, in order, 0x30020, 0x30038, 0x30050, 0x30068, 0x30080, 0x30090, 0x300B0 and 0x300C8.
- R5: When `tristate_en` is low, the eight channel writes are skipped and the block goes straight from the unlock to the frame wait.
- R6: Each write holds its strobe, address and data for as long as `bus_ack` stays low. The next write, or the next step, begins in the cycle after the acknowledge.
- R7: If a write receives no acknowledge during its first TIMEOUT cycles, `seq_err` rises in the next cycle and the strobe drops. Both conditions hold until core-ready is lost.
- R8: After the writes, the block waits until every channel whose `ch_mask` bit is 1 has `ch_valid` high. The `ch_valid` bits of unmasked channels have no effect.
- R9: In the cycle after that condition is seen, `resync_pulse` is high for exactly one cycle.
- R10: `seq_done` rises in the cycle after the resync pulse and stays high while core-ready stays high.
- R11: If core-ready falls, the outputs return to their R1 values in the next cycle. When core-ready rises again, the sequence restarts from the first unlock write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| core_ready | input | 1 | Core reports that it accepts bus traffic |
| tristate_en | input | 1 | Selects whether the eight channel output-enable writes are issued |
| ch_mask | input | NCH | Channels that must show a valid frame before the resync |
| ch_valid | input | NCH | Per-channel valid frame pulse or control character seen |
| bus_ack | input | 1 | Write acknowledge from the bus |
| bus_wr | output | 1 | Write strobe |
| bus_addr | output | ADDR_W | Write address |
| bus_wdata | output | DATA_W | Write data |
| resync_pulse | output | 1 | One-cycle alignment FIFO resync request |
| seq_done | output | 1 | Sequence finished |
| seq_err | output | 1 | A write timed out |

## Verification
The bench keeps the default 20-bit address and data widths and eight channels, so that every table address and data value appears at full size. It lowers TIMEOUT to 16, which lets the unacknowledged-write error be reached within a few dozen cycles. Other parts of the bench vary the acknowledge delay between zero and two cycles and run with the channel writes both enabled and skipped. They also drop core-ready partway through a write, which exercises the hold, skip and restart paths.

// File: rtl/cfg_boot_seq.sv
module cfg_boot_seq #(
  parameter int ADDR_W  = 20,
  parameter int DATA_W  = 20,
  parameter int NCH     = 8,
  parameter int TIMEOUT = 256
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              core_ready,
  input  logic              tristate_en,
  input  logic [NCH-1:0]    ch_mask,
  input  logic [NCH-1:0]    ch_valid,
  input  logic              bus_ack,
  output logic              bus_wr,
  output logic [ADDR_W-1:0] bus_addr,
  output logic [DATA_W-1:0] bus_wdata,
  output logic              resync_pulse,
  output logic              seq_done,
  output logic              seq_err
);
  localparam int NWR = 10;
  localparam int IW  = $clog2(NWR);
  localparam int TW  = (TIMEOUT > 2) ? $clog2(TIMEOUT) : 1;

  typedef enum logic [2:0] {
    S_IDLE, S_WRITE, S_SYNC, S_RESYNC, S_DONE, S_ERR
  } state_t;

  state_t          st;
  logic [IW-1:0]   idx;
  logic [TW-1:0]   tmr;

  function automatic logic [63:0] entry(input logic [IW-1:0] i);
    case (i)
      4'd0:    entry = {32'h0003_0004, 32'h0003_0005};
      4'd1:    entry = {32'h0000_0005, 32'h0000_0080};
      4'd2:    entry = {32'h0003_0020, 32'h0000_0001};
      4'd3:    entry = {32'h0003_0038, 32'h0000_0001};
      4'd4:    entry = {32'h0003_0050, 32'h0000_0001};
      4'd5:    entry = {32'h0003_0068, 32'h0000_0001};
      4'd6:    entry = {32'h0003_0080, 32'h0000_0001};
      4'd7:    entry = {32'h0003_0090, 32'h0000_0001};
      4'd8:    entry = {32'h0003_00B0, 32'h0000_0001};
      default: entry = {32'h0003_00C8, 32'h0000_0001};
    endcase
  endfunction

  logic [63:0] cur;
  assign cur = entry(idx);

  wire last_wr   = tristate_en ? (idx == IW'(NWR - 1)) : (idx == IW'(1));
  wire frames_ok = &(ch_valid | ~ch_mask);
  wire tmo       = (tmr == TW'(TIMEOUT - 1));

  always_ff @(posedge clk) begin
    if (!rst_n || !core_ready) begin
      st  <= S_IDLE;
      idx <= '0;
      tmr <= '0;
    end else begin
      case (st)
        S_IDLE: begin
          st  <= S_WRITE;
          idx <= '0;
          tmr <= '0;
        end
        S_WRITE: begin
          if (bus_ack) begin
            tmr <= '0;
            if (last_wr) st <= S_SYNC;
            else         idx <= idx + IW'(1);
          end else if (tmo) begin
            st <= S_ERR;
          end else begin
            tmr <= tmr + TW'(1);
          end
        end
        S_SYNC:   if (frames_ok) st <= S_RESYNC;
        S_RESYNC: st <= S_DONE;
        default:  st <= st;
      endcase
    end
  end

  assign bus_wr       = (st == S_WRITE);
  assign bus_addr     = bus_wr ? cur[32 +: ADDR_W] : '0;
  assign bus_wdata    = bus_wr ? cur[0 +: DATA_W]  : '0;
  assign resync_pulse = (st == S_RESYNC);
  assign seq_done     = (st == S_DONE);
  assign seq_err      = (st == S_ERR);
endmodule

// File: rtl/cfg_boot_seq_chk.sv
module cfg_boot_seq_chk #(
  parameter int ADDR_W = 20,
  parameter int DATA_W = 20,
  parameter int NCH    = 8
) (
  input logic              clk,
  input logic              rst_n,
  input logic              core_ready,
  input logic [NCH-1:0]    ch_mask,
  input logic [NCH-1:0]    ch_valid,
  input logic              bus_ack,
  input logic              bus_wr,
  input logic [ADDR_W-1:0] bus_addr,
  input logic [DATA_W-1:0] bus_wdata,
  input logic              resync_pulse,
  input logic              seq_done,
  input logic              seq_err
);
  assert_no_write_unready_R11: assert property (@(posedge clk) disable iff (!rst_n)
    !core_ready |=> (!bus_wr && !seq_done && !seq_err && !resync_pulse));

  assert_hold_until_ack_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_wr && !bus_ack && core_ready) |=>
      (seq_err || (bus_wr && $stable(bus_addr) && $stable(bus_wdata))));

  assert_error_sticky_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (seq_err && core_ready) |=> (seq_err && !bus_wr));

  assert_resync_gated_R8: assert property (@(posedge clk) disable iff (!rst_n)
    resync_pulse |-> $past(&(ch_valid | ~ch_mask)));

  assert_resync_single_R9: assert property (@(posedge clk) disable iff (!rst_n)
    resync_pulse |=> !resync_pulse);

  assert_done_sticky_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (seq_done && core_ready) |=> seq_done);

  assert_status_exclusive_R1: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({bus_wr, resync_pulse, seq_done, seq_err}));
endmodule

bind cfg_boot_seq cfg_boot_seq_chk #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .NCH(NCH)) u_chk (
  .clk(clk), .rst_n(rst_n), .core_ready(core_ready), .ch_mask(ch_mask),
  .ch_valid(ch_valid), .bus_ack(bus_ack), .bus_wr(bus_wr), .bus_addr(bus_addr),
  .bus_wdata(bus_wdata), .resync_pulse(resync_pulse), .seq_done(seq_done),
  .seq_err(seq_err)
);

// File: tb/cfg_boot_seq_bench.sv
module cfg_boot_seq_bench;
  localparam int TO = 16;
  localparam int M_IDLE = 0, M_WR = 1, M_SYNC = 2, M_RS = 3, M_DONE = 4, M_ERR = 5;

  logic clk = 0, rst_n = 0, core_ready = 0, tristate_en = 1, bus_ack = 0;
  logic [7:0] ch_mask = 0, ch_valid = 0;
  logic bus_wr, resync_pulse, seq_done, seq_err;
  logic [19:0] bus_addr, bus_wdata;

  always #5 clk = ~clk;

  cfg_boot_seq #(.ADDR_W(20), .DATA_W(20), .NCH(8), .TIMEOUT(TO)) u_cfg_boot_seq (
    .clk(clk), .rst_n(rst_n), .core_ready(core_ready), .tristate_en(tristate_en),
    .ch_mask(ch_mask), .ch_valid(ch_valid), .bus_ack(bus_ack), .bus_wr(bus_wr),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .resync_pulse(resync_pulse),
    .seq_done(seq_done), .seq_err(seq_err));

  int total = 0, bad = 0, cyc = 0;
  int ms = M_IDLE, midx = 0, mtmr = 0;
  bit restarted = 0;
  int exp_a[10] = '{32'h30004, 32'h5, 32'h30020, 32'h30038, 32'h30050,
                    32'h30068, 32'h30080, 32'h30090, 32'h300B0, 32'h300C8};
  int exp_d[10] = '{32'h30005, 32'h80, 1, 1, 1, 1, 1, 1, 1, 1};
  int ack_dly = 0, acnt = 0;
  bit ack_never = 0;

  always @(posedge clk) begin
    cyc++;
    if (!rst_n) ms = M_IDLE;
    else if (!core_ready) begin
      if (ms != M_IDLE) restarted = 1;
      ms = M_IDLE;
    end else begin
      case (ms)
        M_IDLE: begin ms = M_WR; midx = 0; mtmr = 0; end
        M_WR: begin
          if (bus_ack) begin
            mtmr = 0;
            if (midx == (tristate_en ? 9 : 1)) ms = M_SYNC;
            else midx++;
          end else if (mtmr == TO - 1) ms = M_ERR;
          else mtmr++;
        end
        M_SYNC: if ((ch_valid & ch_mask) == ch_mask) ms = M_RS;
        M_RS: ms = M_DONE;
        default: ;
      endcase
    end
  end

  function automatic string tag_of();
    case (ms)
      M_IDLE: return restarted ? "R11" : "R1";
      M_WR:   return (mtmr > 0) ? "R6" : (midx == 0) ? "R2" : (midx == 1) ? "R3" : "R4";
      M_SYNC: return tristate_en ? "R8" : "R5";
      M_RS:   return "R9";
      M_DONE: return "R10";
      default: return "R7";
    endcase
  endfunction

  task automatic chk(input bit ok, input string tag, input string what, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s %s actual=%0h expected=%0h (cycle %0d)", tag, what, act, exp, cyc);
    end
  endtask

  always @(negedge clk) if (rst_n) begin
    string t;
    bit w;
    t = tag_of();
    w = (ms == M_WR);
    chk(bus_wr == w, t, "bus_wr", int'(bus_wr), int'(w));
    chk(bus_addr == (w ? exp_a[midx] : 0), t, "bus_addr", int'(bus_addr), w ? exp_a[midx] : 0);
    chk(bus_wdata == (w ? exp_d[midx] : 0), t, "bus_wdata", int'(bus_wdata), w ? exp_d[midx] : 0);
    chk(resync_pulse == (ms == M_RS), t, "resync_pulse", int'(resync_pulse), int'(ms == M_RS));
    chk(seq_done == (ms == M_DONE), t, "seq_done", int'(seq_done), int'(ms == M_DONE));
    chk(seq_err == (ms == M_ERR), t, "seq_err", int'(seq_err), int'(ms == M_ERR));
  end

  always @(negedge clk) begin
    if (ack_never || !bus_wr) begin bus_ack = 0; acnt = 0; end
    else if (acnt == ack_dly) begin bus_ack = 1; acnt = 0; end
    else begin bus_ack = 0; acnt++; end
  end

  task automatic cycles(input int n);
    repeat (n) @(negedge clk);
  endtask

  initial begin
    fork
      begin
        cycles(3);
        rst_n = 1;
        cycles(5);
        // R2 R3 R4 R8 R9 R10: full table, masked channels with partial validity
        tristate_en = 1; ch_mask = 8'hA5; ch_valid = 8'h05; ack_dly = 0;
        core_ready = 1;
        cycles(20);
        ch_valid = 8'h5A;
        cycles(3);
        ch_valid = 8'hA5;
        cycles(6);
        // R11: drop ready, restart with skipped channel writes and slow ack (R5 R6)
        core_ready = 0; cycles(3);
        tristate_en = 0; ack_dly = 2; ch_mask = 8'h00; ch_valid = 8'h00;
        core_ready = 1;
        cycles(15);
        // R11: drop in the middle of a write
        tristate_en = 1; core_ready = 0; cycles(2);
        core_ready = 1; cycles(5);
        core_ready = 0; cycles(2);
        // R7: no acknowledge
        ack_never = 1; core_ready = 1;
        cycles(TO + 8);
        core_ready = 0; cycles(3);
        ack_never = 0; ack_dly = 1; ch_mask = 8'hFF; ch_valid = 8'hFF;
        core_ready = 1;
        cycles(30);
      end
      begin
        cycles(100000);
        bad++; total++;
        $display("FAIL watchdog expired");
      end
    join_any
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule